// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the coherence engine at the home node of a set of memory blocks in a distributed shared-memory machine. For each block it keeps a full presence vector, with one bit per node, and a single dirty flag. It also holds the block's data. Requesting nodes send shared-read or exclusive-read requests. For each one the controller decides whether to answer from its own storage, to pull the line back from the node that holds it modified, or to invalidate every other sharer before granting ownership.

Only one transaction is in flight at a time. While one is pending, the controller holds a transient busy state and answers every other request with a negative acknowledgement, and the requester retries later. An exclusive grant is held back until every invalidation acknowledgement has come back, so no node can see the new value while stale copies survive elsewhere. Owners may also write a modified line back on their own at any time.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset no message is issued, every block is clean and unshared, and all block data reads as zero.
- R2: A shared read (req_excl=0) to a clean block produces a data reply (msg_type=0) with the stored data to the requester in the cycle after the request, and the requester becomes a sharer.
- R3: A shared read to a dirty block sends a recall (msg_type=1, msg_excl=0) to the owner. After the owner's writeback (rsp_wb=1) the data is stored, the block becomes clean, the old owner stays a sharer, and the requester receives a data reply carrying the written-back value.
- R4: An exclusive read (req_excl=1) to a clean block sends exactly one invalidation (msg_type=2) to every sharer other than the requester, one per cycle.
- R5: The exclusive data reply (msg_type=0, msg_excl=1) is issued only after every invalidation has been acknowledged (rsp_wb=0). The requester then becomes the only holder and the block turns dirty.
- R6: An exclusive read to a block that another node holds dirty sends a recall with msg_excl=1 to that owner. After its writeback the requester is granted ownership, and the old owner no longer counts as a sharer.
- R7: A request that arrives while a transaction is pending is answered in the next cycle with a NACK (msg_type=3) addressed to that requester. It leaves no trace in the directory.
- R8: An unsolicited writeback from the owner of a dirty block stores its data, clears dirty and removes that node from the presence vector.
- R9: A writeback from a node that does not own the block dirty is ignored.
- R10: Whenever a block is dirty, exactly one presence bit of that block is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_node | input | NODE_W | Requesting node |
| req_blk | input | IDX_W | Requested block index |
| req_excl | input | 1 | 0 shared read, 1 exclusive read |
| rsp_valid | input | 1 | Acknowledge or writeback present |
| rsp_wb | input | 1 | 0 invalidation ack, 1 writeback with data |
| rsp_node | input | NODE_W | Responding node |
| rsp_blk | input | IDX_W | Block the response refers to |
| rsp_data | input | DATA_W | Writeback data |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 2 | 0 data, 1 recall, 2 invalidate, 3 NACK |
| msg_node | output | NODE_W | Destination node |
| msg_blk | output | IDX_W | Block index |
| msg_excl | output | 1 | Exclusive grant, or recall that also invalidates |
| msg_data | output | DATA_W | Data for data replies |

## Verification
Directed sequences cover each case on its own: clean reads, reads of a dirty line, exclusive requests with zero, one and several other sharers, exclusive requests against another node's dirty line, and writebacks from the owner and from bystanders. These show whether the controller answers locally, recalls or invalidates. A randomized mix then draws nodes and blocks with a fixed seed and returns acknowledgements after random delays. That pattern separates a grant that waits for the last acknowledgement from one that merely follows the last invalidation. Conflicting requests are injected while a transaction is pending, which tells apart a controller that rejects them from one that disturbs the active entry.

// File: rtl/dirh_pkg.sv
package dirh_pkg;

    typedef enum logic [1:0] {
        MSG_DATA   = 2'd0,
        MSG_RECALL = 2'd1,
        MSG_INVAL  = 2'd2,
        MSG_NACK   = 2'd3
    } msg_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INVAL  = 2'd1,
        ST_WAITWB = 2'd2,
        ST_GRANT  = 2'd3
    } st_e;

endpackage

// File: rtl/dirh_pick.sv
module dirh_pick #(
    parameter int W = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [W-1:0]  onehot,
    output logic [IW-1:0] idx
);
    assign found  = |vec;
    assign onehot = vec & (~vec + W'(1));

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/dirh_popcnt.sv
module dirh_popcnt #(
    parameter int W = 4,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dirh_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int IDX_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int CNT_W  = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NODE_W-1:0] req_node,
    input  logic [IDX_W-1:0]  req_blk,
    input  logic              req_excl,
    input  logic              rsp_valid,
    input  logic              rsp_wb,
    input  logic [NODE_W-1:0] rsp_node,
    input  logic [IDX_W-1:0]  rsp_blk,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    output logic [1:0]        msg_type,
    output logic [NODE_W-1:0] msg_node,
    output logic [IDX_W-1:0]  msg_blk,
    output logic              msg_excl,
    output logic [DATA_W-1:0] msg_data
);

    typedef struct packed {
        st_e                             st;
        logic [NODE_W-1:0]               node;
        logic [IDX_W-1:0]                blk;
        logic                            excl;
        logic [NODES-1:0]                pend;
        logic [CNT_W-1:0]                cnt;
        logic [BLOCKS-1:0][NODES-1:0]    pres;
        logic [BLOCKS-1:0]               dirty;
        logic [BLOCKS-1:0][DATA_W-1:0]   mem;
        logic                            mv;
        msg_e                            mt;
        logic [NODE_W-1:0]               mn;
        logic [IDX_W-1:0]                mb;
        logic                            mx;
        logic [DATA_W-1:0]               md;
    } ctl_t;

    ctl_t q, d;

    logic [NODES-1:0]  req_bit, rsp_bit, act_bit, others;
    logic              own_found, nxt_found;
    logic [NODES-1:0]  own_oh, nxt_oh;
    logic [NODE_W-1:0] own_idx, nxt_idx;
    logic [CNT_W-1:0]  other_cnt;
    logic              wb_hit, recall_done, req_go, ack_in;

    assign req_bit = NODES'(1) << req_node;
    assign rsp_bit = NODES'(1) << rsp_node;
    assign act_bit = NODES'(1) << q.node;
    assign others  = q.pres[req_blk] & ~req_bit;

    dirh_pick #(.W(NODES)) u_own (
        .vec(q.pres[req_blk]), .found(own_found), .onehot(own_oh), .idx(own_idx)
    );

    dirh_pick #(.W(NODES)) u_nxt (
        .vec(q.pend), .found(nxt_found), .onehot(nxt_oh), .idx(nxt_idx)
    );

    dirh_popcnt #(.W(NODES)) u_cnt (
        .vec(others), .cnt(other_cnt)
    );

    assign wb_hit      = rsp_valid && rsp_wb && q.dirty[rsp_blk] && ((q.pres[rsp_blk] & rsp_bit) != '0);
    assign recall_done = wb_hit && (q.st == ST_WAITWB) && (rsp_blk == q.blk);
    assign req_go      = req_valid && (q.st == ST_IDLE) && !(wb_hit && (rsp_blk == req_blk));
    assign ack_in      = rsp_valid && !rsp_wb && (q.st == ST_INVAL) && (rsp_blk == q.blk) && (q.cnt != '0);

    always_comb begin
        d    = q;
        d.mv = 1'b0;
        d.mt = MSG_DATA;
        d.mn = '0;
        d.mb = '0;
        d.mx = 1'b0;
        d.md = '0;

        // writeback not tied to the active recall
        if (wb_hit && !recall_done) begin
            d.mem[rsp_blk]   = rsp_data;
            d.dirty[rsp_blk] = 1'b0;
            d.pres[rsp_blk]  = q.pres[rsp_blk] & ~rsp_bit;
        end

        if (ack_in) d.cnt = q.cnt - CNT_W'(1);

        if (req_valid && !req_go) begin
            d.mv = 1'b1;
            d.mt = MSG_NACK;
            d.mn = req_node;
            d.mb = req_blk;
            d.mx = req_excl;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (req_go) begin
                    d.node = req_node;
                    d.blk  = req_blk;
                    d.excl = req_excl;
                    if (q.dirty[req_blk]) begin
                        d.mv = own_found;
                        d.mt = MSG_RECALL;
                        d.mn = own_idx;
                        d.mb = req_blk;
                        d.mx = req_excl;
                        d.st = ST_WAITWB;
                    end else if (!req_excl) begin
                        d.mv = 1'b1;
                        d.mt = MSG_DATA;
                        d.mn = req_node;
                        d.mb = req_blk;
                        d.md = q.mem[req_blk];
                        d.pres[req_blk] = q.pres[req_blk] | req_bit;
                    end else begin
                        d.pend = others;
                        d.cnt  = other_cnt;
                        d.pres[req_blk]  = req_bit;
                        d.dirty[req_blk] = 1'b1;
                        d.st   = ST_INVAL;
                    end
                end
            end
            ST_INVAL: begin
                if (!req_valid) begin
                    if (nxt_found) begin
                        d.mv   = 1'b1;
                        d.mt   = MSG_INVAL;
                        d.mn   = nxt_idx;
                        d.mb   = q.blk;
                        d.pend = q.pend & ~nxt_oh;
                    end else if (q.cnt == '0) begin
                        d.st = ST_GRANT;
                    end
                end
            end
            ST_WAITWB: begin
                if (recall_done) begin
                    d.mem[q.blk] = rsp_data;
                    if (q.excl) begin
                        d.pres[q.blk] = act_bit;
                    end else begin
                        d.dirty[q.blk] = 1'b0;
                        d.pres[q.blk]  = q.pres[q.blk] | act_bit;
                    end
                    d.st = ST_GRANT;
                end
            end
            ST_GRANT: begin
                if (!req_valid) begin
                    d.mv = 1'b1;
                    d.mt = MSG_DATA;
                    d.mn = q.node;
                    d.mb = q.blk;
                    d.mx = q.excl;
                    d.md = q.mem[q.blk];
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign msg_valid = q.mv;
    assign msg_type  = q.mt;
    assign msg_node  = q.mn;
    assign msg_blk   = q.mb;
    assign msg_excl  = q.mx;
    assign msg_data  = q.md;

    generate
        for (genvar b = 0; b < BLOCKS; b++) begin : g_inv
            // R10
            dirty_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                q.dirty[b] |-> ($countones(q.pres[b]) == 1));
        end
    endgenerate

    // R7
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && q.st != ST_IDLE) |=>
        (msg_valid && msg_type == MSG_NACK && msg_node == $past(req_node)));

    // R5
    no_early_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == MSG_DATA && msg_excl) |-> (q.cnt == '0 && q.pend == '0));

    // R4
    inval_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == MSG_INVAL) |-> (q.cnt != '0));

    // R4
    ack_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_wb && q.st == ST_INVAL) |-> (q.cnt != '0));

endmodule

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb;
    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int DATA_W = 16;
    localparam int NODE_W = 2;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [NODE_W-1:0] req_node = '0;
    logic [IDX_W-1:0]  req_blk = '0;
    logic              req_excl = 1'b0;
    logic              rsp_valid = 1'b0;
    logic              rsp_wb = 1'b0;
    logic [NODE_W-1:0] rsp_node = '0;
    logic [IDX_W-1:0]  rsp_blk = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              msg_valid;
    logic [1:0]        msg_type;
    logic [NODE_W-1:0] msg_node;
    logic [IDX_W-1:0]  msg_blk;
    logic              msg_excl;
    logic [DATA_W-1:0] msg_data;

    always #2 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_node(req_node), .req_blk(req_blk), .req_excl(req_excl),
        .rsp_valid(rsp_valid), .rsp_wb(rsp_wb), .rsp_node(rsp_node), .rsp_blk(rsp_blk),
        .rsp_data(rsp_data),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_node(msg_node), .msg_blk(msg_blk),
        .msg_excl(msg_excl), .msg_data(msg_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [NODES-1:0]  m_pres  [BLOCKS];
    logic              m_dirty [BLOCKS];
    logic [DATA_W-1:0] m_val   [BLOCKS];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int owner_of(logic [NODES-1:0] v);
        for (int i = 0; i < NODES; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic int lowest(logic [NODES-1:0] v);
        for (int i = 0; i < NODES; i++) if (v[i]) return i;
        return 0;
    endfunction

    // One request; bench plays every node. inj >= 0 injects a conflicting request.
    task automatic run_txn(int node, int blk, bit excl, int inj);
        logic [NODES-1:0] bitn, exp_inv, inv_seen, ackq;
        bit exp_rec, busy, got, wb_due, nack_seen, rec_seen;
        int own, cyc, a;
        bitn      = NODES'(1) << node;
        own       = owner_of(m_pres[blk]);
        exp_rec   = m_dirty[blk];
        exp_inv   = (!m_dirty[blk] && excl) ? (m_pres[blk] & ~bitn) : '0;
        busy      = m_dirty[blk] || excl;
        inv_seen  = '0; ackq = '0;
        got = 0; wb_due = 0; nack_seen = 0; rec_seen = 0; cyc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_node = NODE_W'(node); req_blk = IDX_W'(blk); req_excl = excl;
        while (!got && cyc < 80) begin
            @(negedge clk);
            cyc++;
            req_valid = 1'b0; rsp_valid = 1'b0;
            if (cyc == 1 && inj >= 0 && busy) begin
                req_valid = 1'b1; req_node = NODE_W'(inj); req_blk = IDX_W'(blk); req_excl = 1'b0;
            end
            if (msg_valid) begin
                case (msg_type)
                    2'd3: begin
                        chk(inj >= 0 && cyc == 2 && msg_node == NODE_W'(inj), "R7", "nack target", msg_node, inj);
                        nack_seen = 1;
                    end
                    2'd2: begin
                        chk(exp_inv[msg_node] && !inv_seen[msg_node], "R4", "inval target", msg_node, exp_inv);
                        inv_seen[msg_node] = 1'b1;
                        ackq[msg_node] = 1'b1;
                    end
                    2'd1: begin
                        chk(exp_rec && msg_excl == excl, excl ? "R6" : "R3", "recall kind", msg_excl, excl);
                        chk(msg_node == NODE_W'(own), "R10", "recall to sole owner", msg_node, own);
                        rec_seen = 1; wb_due = 1;
                    end
                    default: begin
                        got = 1;
                        chk(msg_node == NODE_W'(node) && msg_blk == IDX_W'(blk), "R2", "reply dest", msg_node, node);
                        chk(msg_data == m_val[blk], exp_rec ? "R3" : "R2", "reply data", msg_data, m_val[blk]);
                        chk(msg_excl == excl, "R5", "reply excl", msg_excl, excl);
                        if (excl && !exp_rec)
                            chk(ackq == '0 && inv_seen == exp_inv, "R5", "grant before acks", ackq, 0);
                        if (exp_rec) chk(rec_seen, excl ? "R6" : "R3", "recall before reply", rec_seen, 1);
                        if (!busy) chk(cyc == 1, "R2", "clean read latency", cyc, 1);
                    end
                endcase
            end
            if (!got) begin
                if (wb_due) begin
                    rsp_valid = 1'b1; rsp_wb = 1'b1; rsp_node = NODE_W'(own);
                    rsp_blk = IDX_W'(blk); rsp_data = m_val[blk];
                    wb_due = 0;
                end else if (ackq != '0 && ($urandom % 3) == 0) begin
                    a = lowest(ackq);
                    ackq[a] = 1'b0;
                    rsp_valid = 1'b1; rsp_wb = 1'b0; rsp_node = NODE_W'(a);
                    rsp_blk = IDX_W'(blk); rsp_data = '0;
                end
            end
        end
        req_valid = 1'b0; rsp_valid = 1'b0;
        chk(got, "R5", "reply arrived", got, 1);
        if (inj >= 0 && busy) chk(nack_seen, "R7", "nack seen", nack_seen, 1);
        if (excl) begin
            m_pres[blk]  = bitn;
            m_dirty[blk] = 1'b1;
            m_val[blk]   = DATA_W'($urandom);
        end else begin
            m_dirty[blk] = 1'b0;
            m_pres[blk]  = m_pres[blk] | bitn;
        end
    endtask

    // Node-initiated writeback (R8 when owner, R9 otherwise)
    task automatic wback(int node, int blk, logic [DATA_W-1:0] v);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_wb = 1'b1; rsp_node = NODE_W'(node);
        rsp_blk = IDX_W'(blk); rsp_data = v;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(!msg_valid, "R9", "no message on writeback", msg_valid, 0);
        if (m_dirty[blk] && m_pres[blk][node]) begin
            m_dirty[blk] = 1'b0;
            m_pres[blk]  = '0;
            m_val[blk]   = v;
        end
    endtask

    initial begin
        #(4ns * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int node, blk, o;
        bit ex;
        void'($urandom(32'd1357));
        for (int b = 0; b < BLOCKS; b++) begin
            m_pres[b] = '0; m_dirty[b] = 1'b0; m_val[b] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!msg_valid, "R1", "idle after reset", msg_valid, 0);

        // R1/R2: fresh block reads zero
        run_txn(0, 0, 0, -1);
        run_txn(1, 0, 0, -1);
        run_txn(2, 0, 0, -1);
        // R4/R5: three sharers invalidated
        run_txn(3, 0, 1, -1);
        // R3: read of dirty line
        run_txn(1, 0, 0, -1);
        // R4/R7: write with conflicting request injected
        run_txn(2, 0, 1, 0);
        // R6: exclusive against dirty owner, with injection
        run_txn(0, 0, 1, 3);
        // R9: bystander writeback ignored, recall still goes to node 0
        wback(1, 0, 16'h1234);
        run_txn(3, 0, 0, -1);
        // R8: owner writeback then clean read
        run_txn(1, 1, 1, -1);
        wback(1, 1, 16'hBEEF);
        run_txn(2, 1, 0, -1);
        // R8: old owner no longer invalidated
        run_txn(3, 1, 1, -1);
        // R5: requester already sole sharer
        run_txn(0, 2, 0, -1);
        run_txn(0, 2, 1, -1);

        for (int t = 0; t < 400; t++) begin
            blk  = $urandom % BLOCKS;
            node = $urandom % NODES;
            ex   = $urandom % 2;
            if (m_dirty[blk] && m_pres[blk][node]) node = (node + 1) % NODES;
            if (($urandom % 8) == 0) begin
                o = $urandom % NODES;
                wback(o, blk, DATA_W'($urandom));
            end else begin
                run_txn(node, blk, ex, (($urandom % 5) == 0) ? int'((node + 1) % NODES) : -1);
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule